// File: doc/BRIEF.md
# Bus Bandwidth Dead-Time Limiter

This block sits between a transfer engine and a bus master port. It caps the share of a shared interconnect the engine can use. Each time the bus reports that an access has completed, the block can hold back the engine's next request for a number of idle clock cycles that software programs. The engine raises `req_i`. The block passes it to the bus as `req_o` only when no idle gap is running. The bus pulses `done_i` when an access completes.

The block uses an 8-bit down-counter that runs on the bus clock. The counter loads on the cycle an access completes and counts down to zero. It loads with the programmed gap length when the feature is enabled, and with zero when it is disabled. A single configuration register holds an enable bit and the gap length. Software writes it through a one-cycle write strobe. A new setting never changes a countdown that is already running. It applies from the next completion onward.

Top module: `dead_time_limiter`

## Requirements
- R1: After reset, the configuration register is disabled with a gap of 0, the counter is 0, and `req_o` equals `req_i`.
- R2: When `cfg_wr_i` is high at a clock edge, the register takes `cfg_data_i`. Bit 8 is the enable and bits 7:0 are the gap length. A completion in the same cycle as the write still loads the value held before that write.
- R3: When the held enable is 0 at a completion, no idle cycles follow, whatever gap is stored.
- R4: When the held enable is 1 with gap N > 0 and `done_i` is high in cycle t, `req_o` is low in cycles t+1 through t+N. From cycle t+N+1 it equals `req_i` again.
- R5: When the held enable is 1 with gap 0, a completion inserts no idle cycle.
- R6: A configuration write during a running countdown leaves that countdown's remaining length unchanged. The new setting applies at the next completion.
- R7: A completion that arrives while a countdown is running restarts the countdown from the full held gap.
- R8: `req_o` is never high while `req_i` is low.
- R9: The largest gap, 255, inserts exactly 255 idle cycles, and the counter stays at 0 once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_i | input | 1 | Configuration register write strobe |
| cfg_data_i | input | 9 | Configuration write data: bit 8 enable, bits 7:0 gap length |
| req_i | input | 1 | Access request from the transfer engine |
| done_i | input | 1 | Access completion pulse from the bus |
| req_o | output | 1 | Request forwarded to the bus master port |

## Verification
Directed gap measurements hold `req_i` high and count the idle cycles after one completion. The settings cover a small gap, a zero gap while enabled, a large gap while disabled, and the maximum of 255. Together these separate a counter that is off by one, ignores the enable, or wraps. Two sequences target timing: a write in the same cycle as a completion, and a write in the middle of a countdown. They distinguish a design that loads from the held register from one that reads the incoming data or reloads at once. A second completion during a countdown shows a restart rather than a continuation. Long stretches with `req_i` and `done_i` toggling, checked on every clock against a behavioural model, confirm that nothing is ever granted without a request.

// File: rtl/dtl_pkg.sv
package dtl_pkg;
  localparam int GAP_W = 8;
  localparam int CFG_W = GAP_W + 1;
  localparam int EN_BIT = GAP_W;

  typedef logic [GAP_W-1:0] gap_t;

  // Value loaded into the counter when an access completes.
  function automatic gap_t load_value(input logic en, input gap_t gap);
    return en ? gap : '0;
  endfunction

  // One step of the idle countdown; saturates at zero.
  function automatic gap_t count_step(input gap_t cnt);
    return (cnt == '0) ? '0 : cnt - gap_t'(1);
  endfunction
endpackage

// File: rtl/dtl_cfg_reg.sv
module dtl_cfg_reg
  import dtl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] data_i,
  output logic             en_o,
  output gap_t             gap_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_o  <= 1'b0;
      gap_o <= '0;
    end else if (wr_i) begin
      en_o  <= data_i[EN_BIT];
      gap_o <= data_i[GAP_W-1:0];
    end
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (en_o == $past(data_i[EN_BIT])) && (gap_o == $past(data_i[GAP_W-1:0])));
  assert_hold_without_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_i |=> $stable(en_o) && $stable(gap_o));
endmodule

// File: rtl/dtl_gap_counter.sv
module dtl_gap_counter
  import dtl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  input  gap_t load_val_i,
  output gap_t cnt_o,
  output logic idle_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else             cnt_o <= count_step(cnt_o);
  end

  assign idle_o = (cnt_o == '0);

  assert_load_exact_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> cnt_o == $past(load_val_i));
  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !idle_o) |=> cnt_o < $past(cnt_o));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && idle_o) |=> idle_o);
endmodule

// File: rtl/dtl_req_gate.sv
module dtl_req_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic open_i,
  output logic req_o
);
  assign req_o = req_i & open_i;

  assert_no_spurious_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> req_i);
  assert_pass_when_open_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (open_i && req_i) |-> req_o);
endmodule

// File: rtl/dead_time_limiter.sv
module dead_time_limiter
  import dtl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_data_i,
  input  logic             req_i,
  input  logic             done_i,
  output logic             req_o
);
  logic cfg_en;
  gap_t cfg_gap;
  gap_t gap_cnt;
  gap_t load_val;
  logic gap_idle;
  logic cnt_load;

  dtl_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_i   (cfg_wr_i),
    .data_i (cfg_data_i),
    .en_o   (cfg_en),
    .gap_o  (cfg_gap)
  );

  assign cnt_load = done_i;
  assign load_val = load_value(cfg_en, cfg_gap);

  dtl_gap_counter u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (load_val),
    .cnt_o      (gap_cnt),
    .idle_o     (gap_idle)
  );

  dtl_req_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (req_i),
    .open_i (gap_idle),
    .req_o  (req_o)
  );

  assert_block_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cfg_en && cfg_gap != '0) |=> !req_o);
  assert_disabled_no_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !cfg_en) |=> gap_idle);
  assert_zero_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && cfg_gap == '0) |=> (req_o == req_i));
  assert_write_mid_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_i && !done_i && !gap_idle) |=> gap_cnt == $past(gap_cnt) - 8'd1);
  assert_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !gap_idle && cfg_en) |=> gap_cnt == $past(cfg_gap));
endmodule

// File: tb/dead_time_limiter_test.sv
module dead_time_limiter_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [8:0] cfg_data = '0;
  logic req = 1'b0;
  logic done = 1'b0;
  logic req_o;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  // behavioural reference
  int m_cnt = 0;
  int m_gap = 0;
  bit m_en = 0;

  always #4 clk = ~clk;

  dead_time_limiter uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_wr_i   (cfg_wr),
    .cfg_data_i (cfg_data),
    .req_i      (req),
    .done_i     (done),
    .req_o      (req_o)
  );

  task automatic check(input bit ok, input string req_tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", req_tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_cnt = 0; m_gap = 0; m_en = 0;
    end else begin
      if (done) m_cnt = m_en ? m_gap : 0;
      else if (m_cnt > 0) m_cnt = m_cnt - 1;
      if (cfg_wr) begin
        m_en = cfg_data[8];
        m_gap = int'(cfg_data[7:0]);
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit exp_o;
      exp_o = req && (m_cnt == 0);
      check(req_o == exp_o, "R4/R8 per-cycle", int'(req_o), int'(exp_o));
    end
  end

  always @(posedge clk) begin
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #2;
    end
  endtask

  task automatic write_cfg(input bit en, input int gap);
    cfg_wr = 1'b1;
    cfg_data = {en, 8'(gap)};
    step(1);
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_done();
    done = 1'b1;
    step(1);
    done = 1'b0;
  endtask

  task automatic count_lows(output int n);
    n = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (req_o) break;
      n++;
    end
    step(1);
  endtask

  task automatic gap_len(output int n);
    req = 1'b1;
    pulse_done();
    count_lows(n);
  endtask

  initial begin
    int n;
    step(2);
    @(negedge clk);
    check(req_o == 1'b0, "R1 reset idle", int'(req_o), 0);
    rst_n = 1'b1;
    step(1);
    req = 1'b1;
    @(negedge clk);
    check(req_o == 1'b1, "R1 pass after reset", int'(req_o), 1);
    step(1);

    gap_len(n);
    check(n == 0, "R1 default no gap", n, 0);

    write_cfg(1'b1, 4);
    gap_len(n);
    check(n == 4, "R4 gap 4", n, 4);

    write_cfg(1'b1, 1);
    gap_len(n);
    check(n == 1, "R4 gap 1", n, 1);

    write_cfg(1'b1, 0);
    gap_len(n);
    check(n == 0, "R5 enabled zero gap", n, 0);

    write_cfg(1'b0, 50);
    gap_len(n);
    check(n == 0, "R3 disabled gap 50", n, 0);

    // R2: write coincident with completion uses old value
    write_cfg(1'b1, 4);
    cfg_wr = 1'b1; cfg_data = {1'b1, 8'd9}; done = 1'b1;
    step(1);
    cfg_wr = 1'b0; done = 1'b0;
    count_lows(n);
    check(n == 4, "R2 same-cycle write keeps old", n, 4);
    gap_len(n);
    check(n == 9, "R2 new value at next load", n, 9);

    // R6: write mid-countdown
    write_cfg(1'b1, 10);
    pulse_done();
    write_cfg(1'b1, 3);
    count_lows(n);
    check(n == 9, "R6 countdown unchanged", n, 9);
    gap_len(n);
    check(n == 3, "R6 new gap next time", n, 3);

    // R7: restart on completion mid-countdown
    write_cfg(1'b1, 6);
    pulse_done();
    step(1);
    pulse_done();
    count_lows(n);
    check(n == 6, "R7 restart full gap", n, 6);

    // R9: maximum gap
    write_cfg(1'b1, 255);
    gap_len(n);
    check(n == 255, "R9 gap 255", n, 255);
    step(3);
    @(negedge clk);
    check(req_o == 1'b1, "R9 stays open after max", int'(req_o), 1);
    step(1);

    // R8: no request, no forward, even idle
    req = 1'b0;
    @(negedge clk);
    check(req_o == 1'b0, "R8 no request", int'(req_o), 0);
    step(1);

    // mixed traffic, compared each clock by the model
    write_cfg(1'b1, 3);
    for (int i = 0; i < 300; i++) begin
      req = (i % 3) != 0;
      done = (i % 7) == 2;
      if (i == 150) begin
        cfg_wr = 1'b1; cfg_data = {1'b1, 8'd5};
      end else if (i == 220) begin
        cfg_wr = 1'b1; cfg_data = {1'b0, 8'd5};
      end else begin
        cfg_wr = 1'b0;
      end
      step(1);
    end
    req = 1'b0; done = 1'b0; cfg_wr = 1'b0;
    step(2);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule